// File: doc/BRIEF.md
# Codebook Dequantizing Multiply-Accumulate Unit

This block is a multiply-accumulate engine for layers whose weights have been clustered into a small set of shared values. The weights reach the block only as short indices. A loadable codebook turns each index back into a 16-bit signed weight. That weight is multiplied at full precision by a signed 16-bit activation, and the product is added into a wide accumulator. Because the lookup only expands the weight and does not narrow the arithmetic, the multiplier and adder always work at the full operand width. The cost is one extra read of the small table for every sample.

The codebook holds up to 256 entries, addressed by an 8-bit index. A narrow mode input restricts lookups to the first 16 entries, which matches a 4-bit index. The caller loads the codebook through a write port while no samples are in flight. It then streams index and activation pairs, marking a sample as the start of a new sum with a clear flag. The caller reads the running sum as a 16-bit Q8.8 value. The value is rounded and saturated, and a register holds it at the output. The codebook read is registered to suit block RAM, so the pipeline has three stages (lookup, multiply, accumulate) and an output register.

Top module: `wshare_mac`

## Requirements
- R1: After reset the result output is 0 and the accumulator is empty. A first sample presented without the clear flag is therefore added to 0.
- R2: A codebook write stores the 16-bit `cb_wr_data` at `cb_wr_addr`, and later lookups of that address return exactly that value.
- R3: In wide mode (`narrow_mode` = 0) all 8 bits of `in_idx` select one of 256 entries.
- R4: In narrow mode (`narrow_mode` = 1) only `in_idx[3:0]` selects an entry among entries 0 to 15, and `in_idx[7:4]` has no effect.
- R5: Each sample with `in_valid` = 1 adds the exact signed product of its decoded weight and its activation (both two's complement Q8.8) into a 40-bit accumulator. Cycles with `in_valid` = 0 add nothing, whatever `in_idx` and `in_act` carry.
- R6: A sample with `in_clear` = 1 starts a new sum that equals its own product. `in_clear` = 1 with `in_valid` = 0 empties the accumulator.
- R7: A sample accepted on rising edge k is reflected in `result` from rising edge k+3 on, and `result` does not yet include it after edge k+2.
- R8: `result` is the accumulator divided by 256, rounded to nearest with halves rounded toward positive infinity, i.e. floor((acc + 128) / 256).
- R9: A rounded value above 32767 reads as 16'h7FFF, and one below -32768 reads as 16'h8000.
- R10: A codebook entry written on one edge is used by a sample accepted on the next edge. Codebook writes and valid samples never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cb_wr_en | input | 1 | Codebook write strobe |
| cb_wr_addr | input | 8 | Codebook entry to write |
| cb_wr_data | input | 16 | Weight value to store (signed Q8.8) |
| narrow_mode | input | 1 | 1: only the low 4 index bits are used |
| in_valid | input | 1 | Qualifies `in_idx`, `in_act` and `in_clear` as a sample |
| in_idx | input | 8 | Codebook index of the sample's weight |
| in_act | input | 16 | Activation, signed Q8.8 |
| in_clear | input | 1 | Start a new sum at this cycle |
| result | output | 16 | Rounded, saturated Q8.8 view of the sum |

## Verification
The embedded assertions check several rules on every cycle:
- the empty state right after reset;
- that an idle cycle leaves both the product and the accumulator untouched;
- that a clear without a sample empties the sum;
- that accumulator values beyond the saturation thresholds map to the two limit codes;
- that no codebook write shares a cycle with a sample.

Other behaviour is visible only through the bench's scenarios: the per-entry codebook contents in both index modes, the masking of the high index bits, the exact rounding at half-LSB boundaries, the three-edge latency, and the sums of mixed signed products across gaps.

// File: rtl/wshare_pkg.sv
package wshare_pkg;
  localparam int WORD_W    = 16;
  localparam int FRAC_BITS = 8;
  localparam int ACC_BITS  = 40;
  localparam int FULL_IDX  = 8;
  localparam int SHORT_IDX = 4;

  typedef enum logic {
    IDX_FULL  = 1'b0,
    IDX_SHORT = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/wshare_lut.sv
module wshare_lut
  import wshare_pkg::*;
#(
  parameter int IDX_W    = FULL_IDX,
  parameter int NARROW_W = SHORT_IDX,
  parameter int DATA_W   = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  idx_mode_e         mode_i,
  input  logic              vld_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] act_i,
  output logic [DATA_W-1:0] w_q,
  output logic [DATA_W-1:0] act_q,
  output logic              vld_q,
  output logic              clr_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] mem [DEPTH];

  // Index masking variant chosen by the short-index width
  generate
    if (NARROW_W < IDX_W) begin : g_mask
      always_comb begin
        rd_addr = idx_i;
        if (mode_i == IDX_SHORT) rd_addr[IDX_W-1:NARROW_W] = '0;
      end
    end else begin : g_pass
      assign rd_addr = idx_i;
    end
  endgenerate

  // Block-RAM style: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (vld_i) w_q <= mem[rd_addr];
  end

  // Side band delayed to line up with the decoded weight
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      clr_q <= 1'b0;
      act_q <= '0;
    end else begin
      vld_q <= vld_i;
      clr_q <= clr_i;
      act_q <= act_i;
    end
  end

  // R10: the table is never written while a sample reads it
  assert_no_write_during_mac_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && vld_i));
endmodule

// File: rtl/wshare_mul.sv
module wshare_mul #(
  parameter int DATA_W = 16,
  parameter int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              vld_i,
  input  logic              clr_i,
  output logic [PROD_W-1:0] prod_q,
  output logic              vld_q,
  output logic              clr_q
);
  logic signed [PROD_W-1:0] prod_d;

  always_comb prod_d = $signed(w_i) * $signed(a_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      clr_q <= clr_i;
      if (vld_i) prod_q <= prod_d;
    end
  end

  // R5: a bubble leaves the product register untouched
  assert_idle_product_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(prod_q));
endmodule

// File: rtl/wshare_acc.sv
module wshare_acc #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = 40,
  parameter int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              vld_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] result_q
);
  localparam longint MAX_L = (longint'(1) << (DATA_W - 1)) - 1;
  localparam longint MIN_L = -(longint'(1) << (DATA_W - 1));
  localparam longint HALF_L = longint'(1) << (FRAC_W - 1);
  localparam longint ONE_L = longint'(1) << FRAC_W;
  localparam logic signed [ACC_W:0] MAX_X = (ACC_W + 1)'(MAX_L);
  localparam logic signed [ACC_W:0] MIN_X = (ACC_W + 1)'(MIN_L);
  localparam logic signed [ACC_W:0] RND_X = (ACC_W + 1)'(HALF_L);
  localparam logic signed [ACC_W-1:0] SAT_HI_ACC = ACC_W'(MAX_L * ONE_L + HALF_L);
  localparam logic signed [ACC_W-1:0] SAT_LO_ACC = ACC_W'(MIN_L * ONE_L - HALF_L);

  logic signed [ACC_W-1:0] acc_q, addend, acc_d;
  logic signed [ACC_W:0]   biased, scaled;
  logic [DATA_W-1:0]       res_d;

  always_comb begin
    addend = vld_i ? {{(ACC_W - PROD_W){prod_i[PROD_W-1]}}, prod_i} : '0;
    acc_d  = clr_i ? addend : acc_q + addend;
  end

  // Round half toward +inf, then clamp to the output range
  always_comb begin
    biased = {acc_q[ACC_W-1], acc_q} + RND_X;
    scaled = biased >>> FRAC_W;
    if (scaled > MAX_X)      res_d = MAX_X[DATA_W-1:0];
    else if (scaled < MIN_X) res_d = MIN_X[DATA_W-1:0];
    else                     res_d = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      acc_q    <= acc_d;
      result_q <= res_d;
    end
  end

  // R1: state is empty on the first cycle out of reset
  assert_acc_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_q == '0 && result_q == '0));
  // R5: no sample and no clear keeps the sum
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!vld_i && !clr_i) |=> $stable(acc_q));
  // R6: a lone clear empties the sum
  assert_clear_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !vld_i) |=> (acc_q == '0));
  // R9: sums past the thresholds read as the limit codes
  assert_sat_high_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= SAT_HI_ACC) |=> (result_q == DATA_W'(MAX_L)));
  assert_sat_low_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_q < SAT_LO_ACC) |=> (result_q == DATA_W'(MIN_L)));
endmodule

// File: rtl/wshare_mac.sv
module wshare_mac
  import wshare_pkg::*;
#(
  parameter int IDX_W    = FULL_IDX,
  parameter int NARROW_W = SHORT_IDX,
  parameter int DATA_W   = WORD_W,
  parameter int FRAC_W   = FRAC_BITS,
  parameter int ACC_W    = ACC_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cb_wr_en,
  input  logic [IDX_W-1:0]  cb_wr_addr,
  input  logic [DATA_W-1:0] cb_wr_data,
  input  logic              narrow_mode,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_act,
  input  logic              in_clear,
  output logic [DATA_W-1:0] result
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] s1_w, s1_act;
  logic              s1_vld, s1_clr;
  logic [PROD_W-1:0] s2_prod;
  logic              s2_vld, s2_clr;

  wshare_lut #(.IDX_W(IDX_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W)) u_lut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cb_wr_en),
    .wr_addr (cb_wr_addr),
    .wr_data (cb_wr_data),
    .mode_i  (idx_mode_e'(narrow_mode)),
    .vld_i   (in_valid),
    .clr_i   (in_clear),
    .idx_i   (in_idx),
    .act_i   (in_act),
    .w_q     (s1_w),
    .act_q   (s1_act),
    .vld_q   (s1_vld),
    .clr_q   (s1_clr)
  );

  wshare_mul #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .w_i    (s1_w),
    .a_i    (s1_act),
    .vld_i  (s1_vld),
    .clr_i  (s1_clr),
    .prod_q (s2_prod),
    .vld_q  (s2_vld),
    .clr_q  (s2_clr)
  );

  wshare_acc #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .PROD_W(PROD_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .prod_i   (s2_prod),
    .vld_i    (s2_vld),
    .clr_i    (s2_clr),
    .result_q (result)
  );
endmodule

// File: tb/wshare_mac_test.sv
module wshare_mac_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cb_wr_en = 1'b0;
  logic [7:0]  cb_wr_addr = '0;
  logic [15:0] cb_wr_data = '0;
  logic        narrow_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_idx = '0;
  logic [15:0] in_act = '0;
  logic        in_clear = 1'b0;
  logic [15:0] result;

  int tests = 0;
  int fails = 0;
  logic [15:0] cb_model [256];

  wshare_mac uut (
    .clk(clk), .rst(rst), .cb_wr_en(cb_wr_en), .cb_wr_addr(cb_wr_addr),
    .cb_wr_data(cb_wr_data), .narrow_mode(narrow_mode), .in_valid(in_valid),
    .in_idx(in_idx), .in_act(in_act), .in_clear(in_clear), .result(result)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint mulq(logic [15:0] w, logic [15:0] a);
    return longint'($signed(w)) * longint'($signed(a));
  endfunction

  function automatic logic [15:0] q_out(longint acc);
    longint r;
    r = (acc + 128) >>> 8;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cb_write(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0;
    cb_wr_en = 1'b1; cb_wr_addr = a; cb_wr_data = d;
    cb_model[a] = d;
  endtask

  task automatic push(logic [7:0] idx, logic [15:0] act, logic clr, logic nar);
    @(negedge clk);
    cb_wr_en = 1'b0;
    in_valid = 1'b1; in_idx = idx; in_act = act; in_clear = clr; narrow_mode = nar;
  endtask

  task automatic bubble(logic [7:0] junk_idx);
    @(negedge clk);
    cb_wr_en = 1'b0; in_valid = 1'b0; in_clear = 1'b0;
    in_idx = junk_idx; in_act = 16'h7A5C;
  endtask

  task automatic flush();
    @(negedge clk);
    cb_wr_en = 1'b0; in_valid = 1'b0; in_clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint acc;
    logic [7:0] ix;
    logic [15:0] av;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset result", result, 16'h0000);

    for (int i = 0; i < 256; i++)
      cb_write(8'(i), 16'((i * 2731 + 16'h03A5) ^ (i << 9)));

    // R1: first sample without clear adds to an empty sum
    push(8'h21, 16'h0180, 1'b0, 1'b0);
    flush();
    check("R1 first sum from zero", result, q_out(mulq(cb_model[8'h21], 16'h0180)));

    // R2/R3: every entry through the full index, activation 1.0
    for (int i = 0; i < 256; i++) begin
      push(8'(i), 16'h0100, 1'b1, 1'b0);
      flush();
      check("R3 wide lookup", result, cb_model[i]);
    end
    check("R2 stored entry", result, cb_model[255]);

    // R4: narrow mode ignores the high index bits
    for (int j = 0; j < 16; j++) begin
      push({4'((j % 15) + 1), 4'(j)}, 16'h0100, 1'b1, 1'b1);
      flush();
      check("R4 narrow lookup", result, cb_model[j]);
    end

    // R5: sums of signed products with junk-carrying bubbles
    for (int p = 0; p < 2; p++) begin
      acc = 0;
      for (int k = 0; k < 8; k++) begin
        ix = 8'(k * 37 + 11 + p * 90);
        av = (p == 0) ? 16'(k * 23 - 90) : 16'(k * 301 - 1100);
        push(ix, av, k == 0, 1'(p));
        acc += mulq(cb_model[p == 1 ? {4'h0, ix[3:0]} : ix], av);
        bubble(~ix);
      end
      flush();
      check("R5 accumulate", result, q_out(acc));
    end

    // R6: clear mid-stream restarts the sum
    push(8'h10, 16'h0200, 1'b1, 1'b0);
    push(8'h11, 16'h0300, 1'b0, 1'b0);
    push(8'h12, 16'h0040, 1'b1, 1'b0);
    push(8'h13, 16'hFF80, 1'b0, 1'b0);
    flush();
    check("R6 clear restarts", result,
          q_out(mulq(cb_model[8'h12], 16'h0040) + mulq(cb_model[8'h13], 16'hFF80)));
    @(negedge clk);
    in_clear = 1'b1; in_valid = 1'b0;
    flush();
    check("R6 clear empties", result, 16'h0000);

    // R7: latency of three edges
    push(8'h44, 16'h0100, 1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 not yet after k+2", result, 16'h0000);
    @(negedge clk);
    check("R7 present after k+3", result, cb_model[8'h44]);

    // R10: write followed at once by a read of the same entry
    cb_write(8'h05, 16'h0200);
    push(8'h05, 16'h0100, 1'b1, 1'b0);
    flush();
    check("R10 write then read", result, 16'h0200);

    // R8: rounding at the half-LSB points
    cb_write(8'h00, 16'h0001);
    cb_write(8'h01, 16'hFFFF);
    push(8'h00, 16'd127, 1'b1, 1'b0); flush();
    check("R8 127/256 -> 0", result, 16'h0000);
    push(8'h00, 16'd128, 1'b1, 1'b0); flush();
    check("R8 128/256 -> 1", result, 16'h0001);
    push(8'h00, 16'd383, 1'b1, 1'b0); flush();
    check("R8 383/256 -> 1", result, 16'h0001);
    push(8'h00, 16'd384, 1'b1, 1'b0); flush();
    check("R8 384/256 -> 2", result, 16'h0002);
    push(8'h01, 16'd128, 1'b1, 1'b0); flush();
    check("R8 -128/256 -> 0", result, 16'h0000);
    push(8'h01, 16'd129, 1'b1, 1'b0); flush();
    check("R8 -129/256 -> -1", result, 16'hFFFF);

    // R9: saturation and the edge just below it
    cb_write(8'h02, 16'h7FFF);
    cb_write(8'h03, 16'h8000);
    push(8'h02, 16'h7FFF, 1'b1, 1'b0); flush();
    check("R9 high clamp", result, 16'h7FFF);
    push(8'h03, 16'h7FFF, 1'b1, 1'b0); flush();
    check("R9 low clamp", result, 16'h8000);
    push(8'h02, 16'h0100, 1'b1, 1'b0);
    push(8'h00, 16'd127, 1'b0, 1'b0); flush();
    check("R9 just below limit", result, 16'h7FFF);
    push(8'h02, 16'h0100, 1'b1, 1'b0);
    push(8'h00, 16'd128, 1'b0, 1'b0);
    push(8'h02, 16'h0100, 1'b0, 1'b0); flush();
    check("R9 above limit", result, 16'h7FFF);
    push(8'h03, 16'h0100, 1'b1, 1'b0);
    push(8'h01, 16'd129, 1'b0, 1'b0); flush();
    check("R9 below negative limit", result, 16'h8000);
    push(8'h02, 16'h0003, 1'b1, 1'b0); flush();
    check("R5 full precision product", result, q_out(mulq(16'h7FFF, 16'h0003)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule